// File: doc/BRIEF.md
# Range-Checking-First Spare Allocator

This block sits between a memory self-test engine and the repair registers of a RAM that has spare rows and spare columns. The test engine reports each failing cell as a row and column address. The allocator drops failures that a spare already in use covers. It keeps up to four other failures in a small local fault map. When the map fills, it stalls the test engine and assigns one spare per cycle until there is room again.

The choice between a spare row and a spare column is greedy. The oldest stored failure is the target. The allocator counts how many stored failures share that target's row and how many share its column. A larger column count selects a spare row. Otherwise, ties included, a spare column is used. If the preferred type is used up, the other type is taken. If both are used up, the memory is flagged as not repairable.

Each assignment is written out as a repair-register write. When the test engine reports that it has finished, the allocator keeps assigning spares until the map is empty, then signals completion. A start pulse begins a new RAM. At that pulse the allocator takes that RAM's spare-row and spare-column limits and clears all earlier state.

Top module: `spare_allocator`

## Requirements
- R1: After reset, and until a start pulse, `bist_pause`, `rpr_we`, `irreparable` and `done` are all low. A start pulse clears every stored failure, every recorded spare and both status flags.
- R2: A reported failure whose row equals a spare row already assigned, or whose column equals a spare column already assigned, is discarded. It takes no map slot and never causes a stall.
- R3: A failure that no spare covers is stored in the fault map when the map has a free slot. `bist_pause` stays low while the map holds fewer than four entries.
- R4: In the cycle after the fourth entry is stored, `bist_pause` is high, and it lasts exactly one cycle. During a pause no fault report is sampled, and one spare is assigned (or the failure is declared).
- R5: The target is the oldest stored entry. If more entries share its column than share its row, a spare row for the target's row is assigned. Otherwise, ties included, a spare column for the target's column is assigned.
- R6: If the preferred spare type has no unused spare left but the other type does, the other type is assigned.
- R7: If a spare is needed and neither type has one left, `irreparable` and `done` rise together in the next cycle. Both stay high until the next start pulse, and `bist_pause` is low.
- R8: Each assignment produces a one-cycle `rpr_we` in the cycle after the decision.
  - The k-th spare row (counting from 0) is written to index k.
  - The k-th spare column is written to index cfg_rows + k.
  - `rpr_val` carries a 1 in its top bit and the row or column address, zero-extended, in the bits below.
- R9: After an assignment, every stored entry in the replaced row (or column) leaves the map. The remaining entries keep their age order.
- R10: `bist_done` ends the test phase. The allocator then keeps assigning spares, one per cycle, until the map is empty. `done` rises in the cycle after the map is seen empty; with an empty map that is two cycles after `bist_done`.
- R11: The spare limits are taken from `cfg_spare_rows` and `cfg_spare_cols` in the start cycle. Later changes on those inputs have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin analysis of a new RAM; samples the spare limits |
| cfg_spare_rows | input | 3 | Spare rows available on this RAM (at most MAX_SR) |
| cfg_spare_cols | input | 3 | Spare columns available on this RAM (at most MAX_SC) |
| flt_valid | input | 1 | A failing cell is reported this cycle |
| flt_row | input | 8 | Row address of the failing cell |
| flt_col | input | 4 | Column address of the failing cell |
| bist_done | input | 1 | The test engine has finished its pass |
| bist_pause | output | 1 | Stall request to the test engine |
| rpr_we | output | 1 | Repair register write strobe |
| rpr_idx | output | 3 | Repair register index |
| rpr_val | output | 9 | Repair register value: valid flag in the top bit, address below |
| irreparable | output | 1 | The RAM cannot be repaired with its spares |
| done | output | 1 | Analysis of the current RAM is finished |

## Verification
The bench targets the tie between row and column counts. A design that broke ties toward rows would write a row index where a column index is expected. It also drives failures that land on a row or column already replaced. If such a failure were stored, the map would fill a fault too early and the whole write sequence would shift. Exhaustion of one spare type is checked: a design without the fallback would call a repairable RAM irreparable. Exhaustion of both types is checked: a design that missed it would keep writing past the spare limits. Draining after the engine finishes, with a full map and with an empty one, and changing the limit inputs after start, show wrong completion timing or wrong column indices.

// File: rtl/spalloc_pkg.sv
`timescale 1ns/1ps
package spalloc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RUN,
        PH_ALLOC,
        PH_DRAIN,
        PH_DONE
    } phase_e;

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spalloc_fmap.sv
`timescale 1ns/1ps
// Local fault map: an age-ordered list, oldest entry always in slot 0.
module spalloc_fmap #(
    parameter int ROW_W = 8,
    parameter int COL_W = 4,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [ROW_W-1:0] push_row,
    input  logic [COL_W-1:0] push_col,
    input  logic             purge,
    input  logic             purge_by_row,
    input  logic [ROW_W-1:0] purge_row,
    input  logic [COL_W-1:0] purge_col,
    output logic [CNT_W-1:0] count,
    output logic [ROW_W-1:0] tgt_row,
    output logic [COL_W-1:0] tgt_col,
    output logic [CNT_W-1:0] row_hits,
    output logic [CNT_W-1:0] col_hits
);

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] cnt;
    } map_t;

    map_t map_d, map_q;
    int   keep_n;
    logic hit;

    always_comb begin
        map_d  = map_q;
        keep_n = 0;
        hit    = 1'b0;
        if (clear) begin
            map_d = '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(map_q.cnt)) begin
                    map_d.ent[i] = '{vld: 1'b1, row: push_row, col: push_col};
                end
            end
            map_d.cnt = map_q.cnt + CNT_W'(1);
        end else if (purge) begin
            map_d.ent = '0;
            for (int i = 0; i < DEPTH; i++) begin
                hit = purge_by_row ? (map_q.ent[i].row == purge_row)
                                   : (map_q.ent[i].col == purge_col);
                if (map_q.ent[i].vld && !hit) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        if (j == keep_n) begin
                            map_d.ent[j] = map_q.ent[i];
                        end
                    end
                    keep_n++;
                end
            end
            map_d.cnt = CNT_W'(keep_n);
        end
    end

    always_comb begin
        row_hits = '0;
        col_hits = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (map_q.ent[i].vld && (map_q.ent[i].row == map_q.ent[0].row)) begin
                row_hits = row_hits + CNT_W'(1);
            end
            if (map_q.ent[i].vld && (map_q.ent[i].col == map_q.ent[0].col)) begin
                col_hits = col_hits + CNT_W'(1);
            end
        end
    end

    assign count   = map_q.cnt;
    assign tgt_row = map_q.ent[0].row;
    assign tgt_col = map_q.ent[0].col;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

endmodule

// File: rtl/spalloc_book.sv
`timescale 1ns/1ps
// Spare bookkeeping: limits, assigned spare addresses, coverage test.
module spalloc_book #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 4,
    parameter int MAX_SR = 4,
    parameter int MAX_SC = 4,
    localparam int SRW = $clog2(MAX_SR + 1),
    localparam int SCW = $clog2(MAX_SC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SRW-1:0]   cfg_r,
    input  logic [SCW-1:0]   cfg_c,
    input  logic             take_row,
    input  logic             take_col,
    input  logic [ROW_W-1:0] addr_row,
    input  logic [COL_W-1:0] addr_col,
    input  logic [ROW_W-1:0] qry_row,
    input  logic [COL_W-1:0] qry_col,
    output logic             covered,
    output logic             rows_left,
    output logic             cols_left,
    output logic [SRW-1:0]   used_r,
    output logic [SCW-1:0]   used_c,
    output logic [SRW-1:0]   lim_r
);

    typedef struct packed {
        logic [SRW-1:0]                lim_r;
        logic [SCW-1:0]                lim_c;
        logic [SRW-1:0]                used_r;
        logic [SCW-1:0]                used_c;
        logic [MAX_SR-1:0][ROW_W-1:0]  rows;
        logic [MAX_SC-1:0][COL_W-1:0]  cols;
    } book_t;

    book_t book_d, book_q;

    always_comb begin
        book_d = book_q;
        if (start) begin
            book_d       = '0;
            book_d.lim_r = (cfg_r > SRW'(MAX_SR)) ? SRW'(MAX_SR) : cfg_r;
            book_d.lim_c = (cfg_c > SCW'(MAX_SC)) ? SCW'(MAX_SC) : cfg_c;
        end else begin
            if (take_row) begin
                for (int i = 0; i < MAX_SR; i++) begin
                    if (i == int'(book_q.used_r)) book_d.rows[i] = addr_row;
                end
                book_d.used_r = book_q.used_r + SRW'(1);
            end
            if (take_col) begin
                for (int i = 0; i < MAX_SC; i++) begin
                    if (i == int'(book_q.used_c)) book_d.cols[i] = addr_col;
                end
                book_d.used_c = book_q.used_c + SCW'(1);
            end
        end
    end

    always_comb begin
        covered = 1'b0;
        for (int i = 0; i < MAX_SR; i++) begin
            if (i < int'(book_q.used_r) && book_q.rows[i] == qry_row) covered = 1'b1;
        end
        for (int i = 0; i < MAX_SC; i++) begin
            if (i < int'(book_q.used_c) && book_q.cols[i] == qry_col) covered = 1'b1;
        end
    end

    assign rows_left = book_q.used_r < book_q.lim_r;
    assign cols_left = book_q.used_c < book_q.lim_c;
    assign used_r    = book_q.used_r;
    assign used_c    = book_q.used_c;
    assign lim_r     = book_q.lim_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            book_q <= '0;
        end else begin
            book_q <= book_d;
        end
    end

endmodule

// File: rtl/spare_allocator.sv
`timescale 1ns/1ps
module spare_allocator
    import spalloc_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 4,
    parameter int DEPTH  = 4,
    parameter int MAX_SR = 4,
    parameter int MAX_SC = 4,
    localparam int SRW   = $clog2(MAX_SR + 1),
    localparam int SCW   = $clog2(MAX_SC + 1),
    localparam int IDX_W = $clog2(MAX_SR + MAX_SC),
    localparam int DW    = wider(ROW_W, COL_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SRW-1:0]   cfg_spare_rows,
    input  logic [SCW-1:0]   cfg_spare_cols,
    input  logic             flt_valid,
    input  logic [ROW_W-1:0] flt_row,
    input  logic [COL_W-1:0] flt_col,
    input  logic             bist_done,
    output logic             bist_pause,
    output logic             rpr_we,
    output logic [IDX_W-1:0] rpr_idx,
    output logic [DW-1:0]    rpr_val,
    output logic             irreparable,
    output logic             done
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PW    = DW - 1;

    typedef struct packed {
        phase_e           phase;
        logic             fin;
        logic             irr;
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    val;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             push, purge, purge_by_row, take_row, take_col;
    logic [CNT_W-1:0] count, row_hits, col_hits;
    logic [ROW_W-1:0] tgt_row;
    logic [COL_W-1:0] tgt_col;
    logic             covered, rows_left, cols_left;
    logic [SRW-1:0]   used_r, lim_r;
    logic [SCW-1:0]   used_c;
    logic             fin_now, prefer_row;

    spalloc_fmap #(.ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start),
        .push        (push),
        .push_row    (flt_row),
        .push_col    (flt_col),
        .purge       (purge),
        .purge_by_row(purge_by_row),
        .purge_row   (tgt_row),
        .purge_col   (tgt_col),
        .count       (count),
        .tgt_row     (tgt_row),
        .tgt_col     (tgt_col),
        .row_hits    (row_hits),
        .col_hits    (col_hits)
    );

    spalloc_book #(.ROW_W(ROW_W), .COL_W(COL_W), .MAX_SR(MAX_SR), .MAX_SC(MAX_SC)) u_book (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_r    (cfg_spare_rows),
        .cfg_c    (cfg_spare_cols),
        .take_row (take_row),
        .take_col (take_col),
        .addr_row (tgt_row),
        .addr_col (tgt_col),
        .qry_row  (flt_row),
        .qry_col  (flt_col),
        .covered  (covered),
        .rows_left(rows_left),
        .cols_left(cols_left),
        .used_r   (used_r),
        .used_c   (used_c),
        .lim_r    (lim_r)
    );

    assign prefer_row = col_hits > row_hits;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.we     = 1'b0;
        fin_now      = ctl_q.fin | bist_done;
        push         = 1'b0;
        purge        = 1'b0;
        purge_by_row = 1'b0;
        take_row     = 1'b0;
        take_col     = 1'b0;
        if (start) begin
            ctl_d       = '0;
            ctl_d.phase = PH_RUN;
        end else begin
            unique case (ctl_q.phase)
                PH_RUN: begin
                    ctl_d.fin = fin_now;
                    push      = flt_valid && !covered;
                    if (push && count == CNT_W'(DEPTH - 1)) begin
                        ctl_d.phase = fin_now ? PH_DRAIN : PH_ALLOC;
                    end else if (fin_now) begin
                        ctl_d.phase = PH_DRAIN;
                    end
                end
                PH_ALLOC, PH_DRAIN: begin
                    ctl_d.fin = fin_now;
                    if (count == '0) begin
                        ctl_d.phase = PH_DONE;
                    end else begin
                        if ((prefer_row && rows_left) || (!cols_left && rows_left)) begin
                            take_row     = 1'b1;
                            purge_by_row = 1'b1;
                        end else if (cols_left) begin
                            take_col     = 1'b1;
                        end
                        if (take_row || take_col) begin
                            purge    = 1'b1;
                            ctl_d.we = 1'b1;
                            if (take_row) begin
                                ctl_d.idx = IDX_W'(used_r);
                                ctl_d.val = {1'b1, PW'(tgt_row)};
                            end else begin
                                ctl_d.idx = IDX_W'(lim_r) + IDX_W'(used_c);
                                ctl_d.val = {1'b1, PW'(tgt_col)};
                            end
                            if (ctl_q.phase == PH_ALLOC) begin
                                ctl_d.phase = fin_now ? PH_DRAIN : PH_RUN;
                            end
                        end else begin
                            ctl_d.irr   = 1'b1;
                            ctl_d.phase = PH_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bist_pause  = ctl_q.phase == PH_ALLOC;
    assign done        = ctl_q.phase == PH_DONE;
    assign irreparable = ctl_q.irr;
    assign rpr_we      = ctl_q.we;
    assign rpr_idx     = ctl_q.idx;
    assign rpr_val     = ctl_q.val;

endmodule

// File: rtl/spare_allocator_chk.sv
`timescale 1ns/1ps
module spare_allocator_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bist_pause,
    input logic rpr_we,
    input logic rpr_flag,
    input logic irreparable,
    input logic done
);

    // R4: a stall lasts one cycle
    a_r4_pause_single: assert property (@(posedge clk) disable iff (!rst_n)
        bist_pause |=> !bist_pause);

    // R4: a stall is followed by a repair write or by the failure flag
    a_r4_pause_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_pause && !start) |=> (rpr_we || irreparable));

    // R8: every repair write carries the valid flag
    a_r8_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        rpr_we |-> rpr_flag);

    // R7: failure implies completion and no stall
    a_r7_irr_done: assert property (@(posedge clk) disable iff (!rst_n)
        irreparable |-> (done && !bist_pause));

    // R7: failure flag holds until the next start
    a_r7_irr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irreparable && !start) |=> irreparable);

    // R10: completion holds until the next start
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10: no writes after completion
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !rpr_we);

endmodule

bind spare_allocator spare_allocator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bist_pause (bist_pause),
    .rpr_we     (rpr_we),
    .rpr_flag   (rpr_val[DW-1]),
    .irreparable(irreparable),
    .done       (done)
);

// File: tb/spare_allocator_test.sv
`timescale 1ns/1ps
module spare_allocator_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cfg_spare_rows = '0;
    logic [2:0] cfg_spare_cols = '0;
    logic       flt_valid = 1'b0;
    logic [7:0] flt_row = '0;
    logic [3:0] flt_col = '0;
    logic       bist_done = 1'b0;
    logic       bist_pause, rpr_we, irreparable, done;
    logic [2:0] rpr_idx;
    logic [8:0] rpr_val;

    always #10 clk = ~clk;

    spare_allocator uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_spare_rows(cfg_spare_rows), .cfg_spare_cols(cfg_spare_cols),
        .flt_valid(flt_valid), .flt_row(flt_row), .flt_col(flt_col),
        .bist_done(bist_done), .bist_pause(bist_pause), .rpr_we(rpr_we),
        .rpr_idx(rpr_idx), .rpr_val(rpr_val), .irreparable(irreparable), .done(done)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // ---------------- reference model ----------------
    typedef struct { int r; int c; } flt_t;
    flt_t m_map[$];
    int   m_srow[$];
    int   m_scol[$];
    int   m_st = 0;      // 0 idle, 1 run, 2 stall, 3 drain, 4 finished
    int   m_lr = 0, m_lc = 0;
    bit   m_fin = 0, m_irr = 0, m_we = 0;
    int   m_idx = 0, m_val = 0;

    function automatic bit in_list(input int q[$], input int v);
        foreach (q[i]) if (q[i] == v) return 1;
        return 0;
    endfunction

    task automatic m_assign();
        int tr = m_map[0].r;
        int tc = m_map[0].c;
        int rh = 0, ch = 0;
        bit use_row, use_col;
        flt_t keep[$];
        foreach (m_map[i]) begin
            if (m_map[i].r == tr) rh++;
            if (m_map[i].c == tc) ch++;
        end
        use_row = (ch > rh) ? (m_srow.size() < m_lr) : (m_scol.size() >= m_lc && m_srow.size() < m_lr);
        use_col = !use_row && (m_scol.size() < m_lc);
        if (use_row) begin
            m_we = 1; m_idx = m_srow.size(); m_val = 256 + tr; m_srow.push_back(tr);
            foreach (m_map[i]) if (m_map[i].r != tr) keep.push_back(m_map[i]);
        end else if (use_col) begin
            m_we = 1; m_idx = m_lr + m_scol.size(); m_val = 256 + tc; m_scol.push_back(tc);
            foreach (m_map[i]) if (m_map[i].c != tc) keep.push_back(m_map[i]);
        end
        if (use_row || use_col) begin
            m_map = keep;
            if (m_st == 2) m_st = m_fin ? 3 : 1;
        end else begin
            m_irr = 1; m_st = 4;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_map.delete(); m_srow.delete(); m_scol.delete();
            m_st = 0; m_fin = 0; m_irr = 0; m_we = 0; m_idx = 0; m_val = 0;
        end else begin
            m_we = 0;
            if (start) begin
                m_map.delete(); m_srow.delete(); m_scol.delete();
                m_lr = cfg_spare_rows; m_lc = cfg_spare_cols;
                m_fin = 0; m_irr = 0; m_idx = 0; m_val = 0; m_st = 1;
            end else if (m_st == 1) begin
                m_fin = m_fin | bist_done;
                if (flt_valid && !in_list(m_srow, flt_row) && !in_list(m_scol, flt_col))
                    m_map.push_back('{r: flt_row, c: flt_col});
                if (m_map.size() == 4) m_st = m_fin ? 3 : 2;
                else if (m_fin) m_st = 3;
            end else if (m_st == 2 || m_st == 3) begin
                m_fin = m_fin | bist_done;
                if (m_map.size() == 0) m_st = 4;
                else m_assign();
            end
        end
    end

    // ---------------- per-cycle comparison and write log ----------------
    bit armed = 0;
    int w_idx[$];
    int w_val[$];

    always @(negedge clk) begin
        if (armed) begin
            chk("R4 pause", bist_pause, m_st == 2);
            chk("R10 done", done, m_st == 4);
            chk("R7 irreparable", irreparable, m_irr);
            chk("R8 write strobe", rpr_we, m_we);
            if (m_we) begin
                chk("R8 write index", rpr_idx, m_idx);
                chk("R8 write value", rpr_val, m_val);
            end
            if (rpr_we) begin
                w_idx.push_back(rpr_idx);
                w_val.push_back(rpr_val);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input int r, input int c);
        start = 1; cfg_spare_rows = 3'(r); cfg_spare_cols = 3'(c);
        tick();
        start = 0;
        w_idx.delete(); w_val.delete();
    endtask

    task automatic fault(input int r, input int c);
        while (bist_pause) tick();
        flt_valid = 1; flt_row = 8'(r); flt_col = 4'(c);
        tick();
        flt_valid = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200 && !done; i++) tick();
    endtask

    task automatic finish_bist();
        while (bist_pause) tick();
        bist_done = 1;
        tick();
        bist_done = 0;
    endtask

    task automatic expect_writes(input string tag, input int idx[$], input int val[$]);
        chk({tag, " write count"}, w_idx.size(), idx.size());
        for (int i = 0; i < idx.size() && i < w_idx.size(); i++) begin
            chk({tag, " index"}, w_idx[i], idx[i]);
            chk({tag, " value"}, w_val[i], val[i]);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int seed;
        repeat (3) tick();
        rst_n = 1;
        tick();
        armed = 1;
        // R1: quiet after reset
        chk("R1 pause after reset", bist_pause, 0);
        chk("R1 write after reset", rpr_we, 0);
        chk("R1 irreparable after reset", irreparable, 0);
        chk("R1 done after reset", done, 0);

        // Limits 2/2; limit inputs then zeroed (R11)
        do_start(2, 2);
        cfg_spare_rows = 0; cfg_spare_cols = 0;
        fault(6, 3); fault(7, 3); fault(14, 5);
        chk("R3 no stall below four entries", bist_pause, 0);
        fault(14, 4);
        chk("R4 stall after fourth entry", bist_pause, 1);
        tick();
        chk("R4 stall lasts one cycle", bist_pause, 0);
        chk("R5 column majority gives spare row", rpr_val, 256 + 6);
        finish_bist();
        wait_done();
        // R5 tie -> column 3; R9 entry (14,4) survives column 5; R6 fallback row 14; R11 col base 2
        expect_writes("R5 R6 R9 R11 sequence", '{0, 2, 3, 1}, '{262, 259, 261, 270});
        chk("R10 done after drain", done, 1);
        chk("R7 repairable RAM", irreparable, 0);

        // Limits 1/1: covered faults and exhaustion
        do_start(1, 1);
        fault(1, 1); fault(2, 2); fault(3, 3); fault(4, 4);
        fault(9, 1);
        chk("R2 covered fault causes no stall", bist_pause, 0);
        fault(5, 5);
        chk("R2 stall only after an uncovered fourth entry", bist_pause, 1);
        fault(2, 7);
        chk("R2 covered by spare row causes no stall", bist_pause, 0);
        fault(6, 6);
        tick();
        chk("R7 irreparable raised", irreparable, 1);
        chk("R7 done with irreparable", done, 1);
        chk("R7 pause low on failure", bist_pause, 0);
        expect_writes("R2 R6 sequence", '{1, 0}, '{257, 258});

        // R1: start clears the flags
        do_start(3, 0);
        chk("R1 start clears irreparable", irreparable, 0);
        chk("R1 start clears done", done, 0);
        // R10: empty map finishes two cycles after bist_done
        bist_done = 1;
        tick();
        bist_done = 0;
        chk("R10 not done one cycle after", done, 0);
        tick();
        chk("R10 done two cycles after", done, 1);
        chk("R10 no writes on empty map", w_idx.size(), 0);

        // Pseudo-random patterns, model compared each cycle
        seed = 12345;
        for (int run = 0; run < 8; run++) begin
            do_start(1 + run % 4, (run * 3) % 5);
            for (int k = 0; k < 24; k++) begin
                seed = seed * 1103515245 + 12345;
                fault((seed >>> 8) & 7, (seed >>> 16) & 3);
            end
            finish_bist();
            wait_done();
            chk("R10 random run finishes", done, 1);
        end

        tick();
        report();
        $finish;
    end

endmodule